// File: doc/BRIEF.md
# Chainable Gated Down Counter

This block is a down counter made of identical slices. Each slice is `SLICE_W` bits wide, and `NUM_SLICES` of them chain into one wide counter. Every slice keeps its own count, period and compare values.

Counting happens only on a block tick (`blk_tick_i`, a clock enable for the slow block clock) while the block is enabled and the gate input is high. The gate is first resynchronized on the fast system clock.

Across the chain, a slice borrows from the slice above it only when every slice below it is at zero. The whole counter reloads from the period values only when all slices are zero together, and that same condition raises terminal count.

A compare output flags whether the full count is at or below the full compare value. A simple write/read port sets the period and compare values and returns any of the three registers.

Top module: `gdc_top`

## Requirements
- R1: `gate_i` passes through a two-stage synchronizer on `clk_i`. A change of `gate_i` affects counting only from the third rising edge after it is driven, and no earlier.
- R2: The full count drops by exactly one at each rising edge where `blk_tick_i`, `en_i` and the synchronized gate are all high and the count is nonzero.
- R3: `tc_o` is high exactly when `en_i` is high, the synchronized gate is high and the full count is zero. With the gate low at zero, `tc_o` stays low.
- R4: A qualifying tick that occurs while `tc_o` is high reloads every slice from its period value.
- R5: When the synchronized gate returns high with the count at zero, `tc_o` rises on that same cycle, so it is valid at the next block tick.
- R6: While `en_i` is low, the count holds, the synchronizer clears, and `tc_o` and `cmp_o` are low. The period, compare and count values are kept.
- R7: A write with `wr_sel_i`=1 (period) stores the period value. It also loads the count only while `en_i` is low.
- R8: `cmp_o` is high when `en_i` is high and the full count is at or below the full compare value. A write with `wr_sel_i`=2 stores the compare value.
- R9: `rd_data_o` returns the following, combinationally: `rd_sel_i`=0 gives the count, 1 gives the period, 2 gives the compare value, and 3 gives zero.
- R10: If a lower slice is at zero and a higher slice is nonzero, a decrement sets the lower slice to all ones and lowers the higher slice by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| blk_tick_i | input | 1 | Block-clock enable, one `clk_i` cycle wide |
| en_i | input | 1 | Block enable |
| gate_i | input | 1 | Asynchronous count gate |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 1 period, 2 compare |
| wr_data_i | input | SLICE_W*NUM_SLICES | Write data, full chain width |
| rd_sel_i | input | 2 | Read select: 0 count, 1 period, 2 compare |
| rd_data_o | output | SLICE_W*NUM_SLICES | Read data |
| tc_o | output | 1 | Chain terminal count |
| cmp_o | output | 1 | Count at or below compare |

## Verification
The bench builds the block with `SLICE_W`=8 and `NUM_SLICES`=2, which gives a 16-bit chain. This is wide enough that a period of 0x0100 drives the low slice through the 00h to FFh wrap with a borrow from the upper slice. It is also narrow enough that random periods of up to 0x01FF reach terminal count and reload many times within a few thousand cycles.

Random gate, enable and write traffic moves the synchronized gate in and out of phase with the ticks. This includes the case where the gate drops and later returns while the count is at zero.

// File: rtl/gdc_pkg.sv
`timescale 1ns/1ps
package gdc_pkg;
  typedef enum logic [1:0] {
    SEL_COUNT   = 2'd0,
    SEL_PERIOD  = 2'd1,
    SEL_COMPARE = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gdc_gate_sync.sv
`timescale 1ns/1ps
module gdc_gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic gate_i,
  output logic gate_s_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sr_q <= '0;
    else if (!en_i) sr_q <= '0;
    else            sr_q <= {sr_q[STAGES-2:0], gate_i};
  end

  assign gate_s_o = sr_q[STAGES-1];

  AST_SYNC_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !gate_s_o); // R6
endmodule

// File: rtl/gdc_slice.sv
`timescale 1ns/1ps
module gdc_slice #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         borrow_i,
  input  logic         reload_i,
  input  logic         wr_per_i,
  input  logic         wr_cmp_i,
  input  logic         wr_ld_i,
  input  logic [W-1:0] wr_data_i,
  output logic         borrow_o,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] per_o,
  output logic [W-1:0] cmpv_o
);
  logic [W-1:0] cnt_q, per_q, cmpv_q;
  logic         zero;

  assign zero     = (cnt_q == '0);
  assign borrow_o = borrow_i & zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      per_q  <= '0;
      cmpv_q <= '0;
    end else begin
      if (wr_per_i) per_q  <= wr_data_i;
      if (wr_cmp_i) cmpv_q <= wr_data_i;
      if (run_i && reload_i)      cnt_q <= per_q;
      else if (run_i && borrow_i) cnt_q <= cnt_q - 1'b1;
      else if (wr_ld_i)           cnt_q <= wr_data_i;
    end
  end

  assign cnt_o  = cnt_q;
  assign per_o  = per_q;
  assign cmpv_o = cmpv_q;

  AST_SLICE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && borrow_i && !reload_i && zero) |=> (cnt_q == '1)); // R10
endmodule

// File: rtl/gdc_top.sv
`timescale 1ns/1ps
module gdc_top
  import gdc_pkg::*;
#(
  parameter int SLICE_W    = 8,
  parameter int NUM_SLICES = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          blk_tick_i,
  input  logic                          en_i,
  input  logic                          gate_i,
  input  logic                          wr_en_i,
  input  logic [1:0]                    wr_sel_i,
  input  logic [SLICE_W*NUM_SLICES-1:0] wr_data_i,
  input  logic [1:0]                    rd_sel_i,
  output logic [SLICE_W*NUM_SLICES-1:0] rd_data_o,
  output logic                          tc_o,
  output logic                          cmp_o
);
  localparam int CW = SLICE_W * NUM_SLICES;

  logic            gate_s, run, all_zero, wr_per, wr_cmp, wr_ld;
  logic [NUM_SLICES:0] borrow;
  logic [CW-1:0]   cnt_full, per_full, cmp_full;

  gdc_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .en_i, .gate_i, .gate_s_o(gate_s)
  );

  assign run    = blk_tick_i & en_i & gate_s;
  assign wr_per = wr_en_i & (wr_sel_i == SEL_PERIOD);
  assign wr_cmp = wr_en_i & (wr_sel_i == SEL_COMPARE);
  assign wr_ld  = wr_per & ~en_i;

  // slice 0 always has a borrow request; chain ripples upward
  assign borrow[0] = 1'b1;
  assign all_zero  = borrow[NUM_SLICES];

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    gdc_slice #(.W(SLICE_W)) u_slice (
      .clk_i,
      .rst_ni,
      .run_i     (run),
      .borrow_i  (borrow[k]),
      .reload_i  (all_zero),
      .wr_per_i  (wr_per),
      .wr_cmp_i  (wr_cmp),
      .wr_ld_i   (wr_ld),
      .wr_data_i (wr_data_i[k*SLICE_W +: SLICE_W]),
      .borrow_o  (borrow[k+1]),
      .cnt_o     (cnt_full[k*SLICE_W +: SLICE_W]),
      .per_o     (per_full[k*SLICE_W +: SLICE_W]),
      .cmpv_o    (cmp_full[k*SLICE_W +: SLICE_W])
    );
  end

  assign tc_o  = en_i & gate_s & all_zero;
  assign cmp_o = en_i & (cnt_full <= cmp_full);

  always_comb begin
    unique case (rd_sel_i)
      SEL_COUNT:   rd_data_o = cnt_full;
      SEL_PERIOD:  rd_data_o = per_full;
      SEL_COMPARE: rd_data_o = cmp_full;
      default:     rd_data_o = '0;
    endcase
  end

  AST_RELOAD_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && tc_o) |=> (cnt_full == $past(per_full))); // R4
  AST_DECREMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !tc_o) |=> (cnt_full == CW'($past(cnt_full) - 1'b1))); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !wr_ld) |=> $stable(cnt_full)); // R6
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && $past(!en_i)) |-> (!tc_o && !cmp_o)); // R6
endmodule

// File: tb/gdc_top_bench.sv
`timescale 1ns/1ps
module gdc_top_bench;
  localparam int SW = 8;
  localparam int NS = 2;
  localparam int CW = SW * NS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0, en = 1'b0, gate = 1'b0, wr = 1'b0;
  logic [1:0]    wsel = 2'd0, rsel = 2'd0;
  logic [CW-1:0] wdata = '0;
  logic [CW-1:0] rdata;
  logic          tc, cmp;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // reference model
  logic [CW-1:0] m_cnt = '0, m_per = '0, m_cmp = '0;
  logic          m_g1 = 1'b0, m_g2 = 1'b0;

  always #2.5 clk = ~clk;

  gdc_top #(.SLICE_W(SW), .NUM_SLICES(NS)) u_gdc_top (
    .clk_i(clk), .rst_ni(rst_n), .blk_tick_i(tick), .en_i(en), .gate_i(gate),
    .wr_en_i(wr), .wr_sel_i(wsel), .wr_data_i(wdata), .rd_sel_i(rsel),
    .rd_data_o(rdata), .tc_o(tc), .cmp_o(cmp)
  );

  task automatic chk(input logic [CW-1:0] act, input logic [CW-1:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_tc();
    return en & m_g2 & (m_cnt == '0);
  endfunction

  function automatic logic exp_cmp();
    return en & (m_cnt <= m_cmp);
  endfunction

  // drive at negedge, clock once, update model, check 1 ns after the edge
  task automatic step(input logic t, input logic e, input logic g,
                      input logic w, input logic [1:0] s, input logic [CW-1:0] d,
                      input string tag);
    logic run;
    logic [CW-1:0] n_cnt;
    @(negedge clk);
    tick = t; en = e; gate = g; wr = w; wsel = s; wdata = d; rsel = 2'd0;
    @(posedge clk);
    run   = t & e & m_g2;
    n_cnt = m_cnt;
    if (run) n_cnt = (m_cnt == '0) ? m_per : m_cnt - 1'b1;
    else if (w && s == 2'd1 && !e) n_cnt = d;
    if (w && s == 2'd1) m_per = d;
    if (w && s == 2'd2) m_cmp = d;
    m_cnt = n_cnt;
    if (!e) begin m_g1 = 1'b0; m_g2 = 1'b0; end
    else begin m_g2 = m_g1; m_g1 = g; end
    #1;
    chk(rdata, m_cnt, {tag, " count"});
    chk(CW'(tc), CW'(exp_tc()), "R3 tc");
    chk(CW'(cmp), CW'(exp_cmp()), "R8 cmp");
  endtask

  task automatic rd_chk(input logic [1:0] s, input logic [CW-1:0] exp, input string tag);
    rsel = s;
    #0.5;
    chk(rdata, exp, tag);
    rsel = 2'd0;
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(rdata, '0, "reset count");
    chk(CW'(tc), '0, "reset tc");
    rst_n = 1'b1;

    // R7 / R9: period and compare writes while disabled
    step(0, 0, 0, 1, 2'd1, 16'd5, "R7 load");
    step(0, 0, 0, 1, 2'd2, 16'd2, "R8 cmpw");
    rd_chk(2'd1, 16'd5, "R9 period read");
    rd_chk(2'd2, 16'd2, "R9 compare read");
    rd_chk(2'd3, 16'd0, "R9 unused read");

    // R1: gate rises with ticks every cycle; first two edges must not count
    step(1, 1, 1, 0, 0, 0, "R1 sync1");
    step(1, 1, 1, 0, 0, 0, "R1 sync2");
    chk(rdata, 16'd5, "R1 held");
    // R2/R3/R4: count down through zero and reload
    for (int i = 0; i < 7; i++) step(1, 1, 1, 0, 0, 0, "R2 down");

    // run to zero, then gate low at zero: tc must drop (R3), resume (R5)
    while (m_cnt != 0) step(1, 1, 1, 0, 0, 0, "R2 drain");
    chk(CW'(tc), 16'd1, "R3 tc at zero");
    step(0, 1, 0, 0, 0, 0, "R3 gate off");
    step(0, 1, 0, 0, 0, 0, "R3 gate off");
    chk(CW'(tc), 16'd0, "R3 tc gated low");
    step(0, 1, 1, 0, 0, 0, "R5 regate");
    step(0, 1, 1, 0, 0, 0, "R5 regate");
    chk(CW'(tc), 16'd1, "R5 tc back");
    step(1, 1, 1, 0, 0, 0, "R4 reload");
    chk(rdata, 16'd5, "R4 reloaded");

    // R7: period write while enabled leaves count
    step(0, 1, 1, 1, 2'd1, 16'h0100, "R7 enabled write");
    chk(rdata, 16'd5, "R7 count kept");
    // R6: disable keeps data, silences outputs
    step(0, 0, 1, 0, 0, 0, "R6 off");
    step(1, 0, 1, 0, 0, 0, "R6 off tick");
    chk(rdata, 16'd5, "R6 retained");
    chk(CW'(tc | cmp), 16'd0, "R6 outputs low");

    // R10: 0x0100 -> 0x00FF wrap with borrow
    step(0, 0, 1, 1, 2'd1, 16'h0100, "R10 load");
    step(0, 1, 1, 0, 0, 0, "R10 sync");
    step(0, 1, 1, 0, 0, 0, "R10 sync");
    step(1, 1, 1, 0, 0, 0, "R10 wrap");
    chk(rdata, 16'h00FF, "R10 wrapped");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic t, e, g, w;
      logic [1:0] s;
      logic [CW-1:0] d;
      t = ($urandom % 3) == 0;
      e = ($urandom % 16) != 0;
      g = ($urandom % 8) != 0;
      w = ($urandom % 20) == 0;
      s = ($urandom % 2) ? 2'd1 : 2'd2;
      d = CW'($urandom) & 16'h01FF;
      step(t, e, g, w, s, d, "R2 random");
      if (i % 97 == 0) rd_chk(2'd1, m_per, "R9 random period");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule